// File: doc/BRIEF.md
# Expansion-card EEPROM command mailbox

The block gives a processor word-wide read access to the identification EEPROMs of up to three expansion cards through two 16-bit registers on a simple register bus. Software first writes a slot select code to the select register. It then writes a two-word read command to the data register: the first word carries the 6-bit byte address in its low bits (a read command is 0x180 plus the address), and the second word is zero and only completes the command. A following read of the data register returns the addressed byte in the high half and the next byte in the low half. That read consumes the command.

The select register reads back as a presence mask: all ones, except that the bit of each populated slot is cleared. The EEPROM contents are outside the block. They are reached through a combinational byte-read port that presents a slot index and two byte addresses, and that returns two bytes in the same cycle. Every case that cannot give real data returns 0xFFFF: no command pending, an unknown select code, or a selected slot with no card.

Top module: `eeprom_cmd_mailbox`

## Requirements
- R1: After reset, rdata_o is 0x0000, rom_slot_o is 3 (none selected), rom_addr0_o is 0 and rom_addr1_o is 1. No command is pending and the next data-register write is taken as word 0.
- R2: Writes to offset 0x42 alternate between word 0 and word 1. Word 0 is stored. After word 1 the position returns to word 0 and the command becomes pending. A read does not change the position.
- R3: rom_addr0_o equals bits 5:0 of the last stored word 0, and rom_addr1_o equals that value plus 1 modulo 64.
- R4: A read of 0x42 with a command pending, a slot selected and that slot present returns the byte at rom_addr0_o in bits 15:8 and the byte at rom_addr1_o in bits 7:0. The read then clears the pending state.
- R5: A read of 0x42 with no command pending returns 0xFFFF.
- R6: A write to 0x12 latches the select code. 0x1700 selects slot 0, 0x1D00 selects slot 1 and 0x3500 selects slot 2; rom_slot_o shows the slot number. Any other code gives rom_slot_o = 3, and a pending data read then returns 0xFFFF.
- R7: A pending data read whose selected slot has present_i low returns 0xFFFF and still clears the pending state.
- R8: A read of 0x12 returns 0xFFFF with bit n cleared for each n in 0..2 where present_i[n] is 1.
- R9: A read of any other offset returns 0x0000. A write to any other offset changes no state.
- R10: Read data appears on rdata_o in the clock cycle after the read strobe. rdata_o holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Register offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| present_i | input | 3 | Per-slot card presence, 1 = populated |
| rom_slot_o | output | 2 | Selected slot, 3 = none |
| rom_addr0_o | output | 6 | Address of the high byte |
| rom_addr1_o | output | 6 | Address of the low byte |
| rom_data0_i | input | 8 | Byte at rom_addr0_o |
| rom_data1_i | input | 8 | Byte at rom_addr1_o |

## Verification
The properties assume that present_i and the bus inputs are stable across each rising clock edge, and that req_i is low while reset is applied. The presence check also relies on present_i in the strobe cycle being the value to be reported. The bench changes every input only on falling edges and keeps req_i low during and just after reset. Select codes, slot presence and command addresses, including the wrap at address 63, are varied only between accesses.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned NUM_SLOTS = 3;
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS + 1);
  localparam logic [15:0] SEL_CODE [NUM_SLOTS] = '{16'h1700, 16'h1D00, 16'h3500};
endpackage

// File: rtl/mbx_slot_decode.sv
module mbx_slot_decode #(
  parameter int unsigned DW = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [DW-1:0]               wdata_i,
  output logic [mbx_pkg::SLOT_W-1:0]  slot_o
);
  localparam int unsigned NS = mbx_pkg::NUM_SLOTS;
  localparam int unsigned SW = mbx_pkg::SLOT_W;

  logic [DW-1:0] code_q;
  logic [NS-1:0] match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   code_q <= '0;
    else if (wr_i) code_q <= wdata_i;
  end

  for (genvar g = 0; g < NS; g++) begin : g_match
    assign match[g] = (code_q == DW'(mbx_pkg::SEL_CODE[g]));
  end

  always_comb begin
    slot_o = SW'(NS);
    for (int i = NS - 1; i >= 0; i--) begin
      if (match[i]) slot_o = SW'(i);
    end
  end
endmodule

// File: rtl/mbx_cmd_seq.sv
module mbx_cmd_seq #(
  parameter int unsigned EAW = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic           rd_i,
  input  logic [EAW-1:0] waddr_i,
  output logic           valid_o,
  output logic           pos_o,
  output logic [EAW-1:0] addr0_o,
  output logic [EAW-1:0] addr1_o
);
  logic           pos_q, valid_q;
  logic [EAW-1:0] w0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= 1'b0;
      valid_q <= 1'b0;
      w0_q    <= '0;
    end else if (wr_i) begin
      if (!pos_q) begin
        w0_q  <= waddr_i;
        pos_q <= 1'b1;
      end else begin
        pos_q   <= 1'b0;
        valid_q <= 1'b1;
      end
    end else if (rd_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign pos_o   = pos_q;
  assign addr0_o = w0_q;
  assign addr1_o = w0_q + EAW'(1);  // wraps modulo 2**EAW
endmodule

// File: rtl/mbx_read_mux.sv
module mbx_read_mux #(
  parameter int unsigned DW = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         rd_sel_i,
  input  logic                         rd_dat_i,
  input  logic                         rd_oth_i,
  input  logic                         valid_i,
  input  logic                         slot_ok_i,
  input  logic [mbx_pkg::NUM_SLOTS-1:0] present_i,
  input  logic [DW/2-1:0]              byte0_i,
  input  logic [DW/2-1:0]              byte1_i,
  output logic [DW-1:0]                rdata_o
);
  localparam int unsigned NS = mbx_pkg::NUM_SLOTS;

  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_sel_i) begin
      rdata_q <= {{(DW-NS){1'b1}}, ~present_i};
    end else if (rd_dat_i) begin
      rdata_q <= (valid_i && slot_ok_i) ? {byte0_i, byte1_i} : '1;
    end else if (rd_oth_i) begin
      rdata_q <= '0;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/eeprom_cmd_mailbox.sv
module eeprom_cmd_mailbox #(
  parameter int unsigned DW       = 16,
  parameter int unsigned AW       = 8,
  parameter int unsigned EAW      = 6,
  parameter logic [7:0]  OFS_SEL  = 8'h12,
  parameter logic [7:0]  OFS_DATA = 8'h42
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [AW-1:0]               addr_i,
  input  logic [DW-1:0]               wdata_i,
  output logic [DW-1:0]               rdata_o,
  input  logic [mbx_pkg::NUM_SLOTS-1:0] present_i,
  output logic [mbx_pkg::SLOT_W-1:0]  rom_slot_o,
  output logic [EAW-1:0]              rom_addr0_o,
  output logic [EAW-1:0]              rom_addr1_o,
  input  logic [DW/2-1:0]             rom_data0_i,
  input  logic [DW/2-1:0]             rom_data1_i
);
  localparam int unsigned NS = mbx_pkg::NUM_SLOTS;

  logic hit_sel, hit_dat;
  logic wr_sel, wr_dat, rd_sel, rd_dat, rd_oth;
  logic cmd_valid, cmd_pos, slot_ok;

  assign hit_sel = (addr_i == AW'(OFS_SEL));
  assign hit_dat = (addr_i == AW'(OFS_DATA));
  assign wr_sel  = req_i &  we_i & hit_sel;
  assign wr_dat  = req_i &  we_i & hit_dat;
  assign rd_sel  = req_i & ~we_i & hit_sel;
  assign rd_dat  = req_i & ~we_i & hit_dat;
  assign rd_oth  = req_i & ~we_i & ~hit_sel & ~hit_dat;

  mbx_slot_decode #(.DW(DW)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_sel),
    .wdata_i(wdata_i),
    .slot_o (rom_slot_o)
  );

  mbx_cmd_seq #(.EAW(EAW)) u_cmd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_dat),
    .rd_i   (rd_dat),
    .waddr_i(wdata_i[EAW-1:0]),
    .valid_o(cmd_valid),
    .pos_o  (cmd_pos),
    .addr0_o(rom_addr0_o),
    .addr1_o(rom_addr1_o)
  );

  always_comb begin
    slot_ok = 1'b0;
    for (int i = 0; i < NS; i++) begin
      if (rom_slot_o == mbx_pkg::SLOT_W'(i)) slot_ok = present_i[i];
    end
  end

  mbx_read_mux #(.DW(DW)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_sel_i (rd_sel),
    .rd_dat_i (rd_dat),
    .rd_oth_i (rd_oth),
    .valid_i  (cmd_valid),
    .slot_ok_i(slot_ok),
    .present_i(present_i),
    .byte0_i  (rom_data0_i),
    .byte1_i  (rom_data1_i),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int unsigned DW       = 16,
  parameter int unsigned AW       = 8,
  parameter logic [7:0]  OFS_SEL  = 8'h12,
  parameter logic [7:0]  OFS_DATA = 8'h42
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [2:0]    present_i,
  input logic [DW-1:0] rdata_o,
  input logic          cmd_valid,
  input logic          cmd_pos
);
  logic dat_wr, dat_rd, sel_rd;
  assign dat_wr = req_i &  we_i & (addr_i == AW'(OFS_DATA));
  assign dat_rd = req_i & ~we_i & (addr_i == AW'(OFS_DATA));
  assign sel_rd = req_i & ~we_i & (addr_i == AW'(OFS_SEL));

  p_valid_after_two_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr && cmd_pos) |=> (cmd_valid && !cmd_pos));

  p_first_word_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr && !cmd_pos) |=> (cmd_pos && (cmd_valid == $past(cmd_valid))));

  p_read_consumes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_rd |=> !cmd_valid);

  p_idle_ffff_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_rd && !cmd_valid) |=> (rdata_o == '1));

  p_presence_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_rd |=> ((rdata_o[2:0] == ~$past(present_i)) && (&rdata_o[DW-1:3])));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(rdata_o));
endmodule

bind eeprom_cmd_mailbox mbx_checker #(
  .DW(DW), .AW(AW), .OFS_SEL(OFS_SEL), .OFS_DATA(OFS_DATA)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .present_i(present_i),
  .rdata_o  (rdata_o),
  .cmd_valid(cmd_valid),
  .cmd_pos  (cmd_pos)
);

// File: tb/sim_eeprom_cmd_mailbox.sv
`timescale 1ns/1ps
module sim_eeprom_cmd_mailbox;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  present = 3'b000;
  logic [1:0]  rom_slot;
  logic [5:0]  rom_a0, rom_a1;
  logic [7:0]  rom_b0, rom_b1;

  int checks = 0, bad = 0;
  bit done = 0;
  string cur = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rom_fn(int slot, int a);
    return 8'(((slot * 64 + a) * 37 + 11) & 255);
  endfunction

  assign rom_b0 = rom_fn(int'(rom_slot), int'(rom_a0));
  assign rom_b1 = rom_fn(int'(rom_slot), int'(rom_a1));

  eeprom_cmd_mailbox u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .present_i(present),
    .rom_slot_o(rom_slot), .rom_addr0_o(rom_a0), .rom_addr1_o(rom_a1),
    .rom_data0_i(rom_b0), .rom_data1_i(rom_b1)
  );

  // reference model
  int m_pos, m_valid, m_w0, m_slot;
  logic [15:0] m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_valid = 0; m_w0 = 0; m_slot = -1; m_rd = 16'h0000;
    end else if (req) begin
      if (we) begin
        if (addr == 8'h12) begin
          case (wdata)
            16'h1700: m_slot = 0;
            16'h1D00: m_slot = 1;
            16'h3500: m_slot = 2;
            default:  m_slot = -1;
          endcase
        end else if (addr == 8'h42) begin
          if (m_pos == 0) begin m_w0 = int'(wdata) % 64; m_pos = 1; end
          else begin m_pos = 0; m_valid = 1; end
        end
      end else begin
        if (addr == 8'h12) m_rd = 16'hFFFF & ~{13'h0, present};
        else if (addr == 8'h42) begin
          if (m_valid == 1 && m_slot >= 0 && present[m_slot])
            m_rd = {rom_fn(m_slot, m_w0), rom_fn(m_slot, (m_w0 + 1) % 64)};
          else
            m_rd = 16'hFFFF;
          m_valid = 0;
        end else m_rd = 16'h0000;
      end
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({cur, " R10 rdata"}, rdata, m_rd);
      check("R3 addr0", {10'h0, rom_a0}, 16'(m_w0));
      check("R3 addr1", {10'h0, rom_a1}, 16'((m_w0 + 1) % 64));
      check("R6 slot", {14'h0, rom_slot}, (m_slot < 0) ? 16'd3 : 16'(m_slot));
    end
  end

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic cmd(int a);
    wr(8'h42, 16'h0180 | 16'(a));
    wr(8'h42, 16'h0000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", rdata, 16'h0000);
    check("R1 slot", {14'h0, rom_slot}, 16'd3);
    check("R1 addr0", {10'h0, rom_a0}, 16'd0);
    check("R1 addr1", {10'h0, rom_a1}, 16'd1);

    // R5 nothing pending
    cur = "R5";
    present = 3'b111;
    rd(8'h42, v); check("R5 idle read", v, 16'hFFFF);

    // R4 basic read, slot 0
    cur = "R4";
    wr(8'h12, 16'h1700);
    cmd(5);
    rd(8'h42, v); check("R4 slot0 addr5", v, {rom_fn(0, 5), rom_fn(0, 6)});
    rd(8'h42, v); check("R4 consumed", v, 16'hFFFF);

    // R3 wrap at 63, slot 1
    cur = "R3";
    wr(8'h12, 16'h1D00);
    cmd(63);
    rd(8'h42, v); check("R3 wrap", v, {rom_fn(1, 63), rom_fn(1, 0)});

    // R2 position survives an interleaved read
    cur = "R2";
    wr(8'h12, 16'h3500);
    wr(8'h42, 16'h0180 | 16'd20);
    rd(8'h42, v); check("R2 half command", v, 16'hFFFF);
    wr(8'h42, 16'h0000);
    rd(8'h42, v); check("R2 completed", v, {rom_fn(2, 20), rom_fn(2, 21)});

    // R6 unknown code
    cur = "R6";
    wr(8'h12, 16'h1701);
    check("R6 none", {14'h0, rom_slot}, 16'd3);
    cmd(7);
    rd(8'h42, v); check("R6 bad code", v, 16'hFFFF);

    // R7 empty slot
    cur = "R7";
    wr(8'h12, 16'h1D00);
    present = 3'b101;
    cmd(9);
    rd(8'h42, v); check("R7 empty", v, 16'hFFFF);
    present = 3'b111;
    rd(8'h42, v); check("R7 cleared", v, 16'hFFFF);

    // R8 presence patterns
    cur = "R8";
    for (int p = 0; p < 8; p++) begin
      present = 3'(p);
      rd(8'h12, v); check("R8 presence", v, 16'hFFFF & ~16'(p));
    end
    present = 3'b111;

    // R9 other offsets
    cur = "R9";
    rd(8'h20, v); check("R9 other read", v, 16'h0000);
    wr(8'h12, 16'h1700);
    wr(8'h42, 16'h0180 | 16'd30);
    wr(8'h20, 16'h0000);
    wr(8'h40, 16'h1234);
    rd(8'h42, v); check("R9 other write no advance", v, 16'hFFFF);
    wr(8'h42, 16'h0000);
    rd(8'h42, v); check("R9 pending", v, {rom_fn(0, 30), rom_fn(0, 31)});

    // R10 hold over idle cycles
    cur = "R10";
    repeat (5) @(negedge clk);
    check("R10 hold", rdata, {rom_fn(0, 30), rom_fn(0, 31)});

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule